// File: doc/BRIEF.md
# Serial Slave Channel with Frame Error Monitor

This block is the receive/transmit core of a synchronous serial slave. A remote master drives a shift clock and a serial data line into it. On every rising shift-clock edge the block shifts one input bit into a 16-bit shift register, most significant bit first, and presents the register's top bit on its serial output. After the sixteenth edge the captured word moves to a receive buffer. Words for the master enter through a single-entry transmit buffer. That buffer is copied into the shift register whenever no frame is in progress. The serial inputs are assumed to be already synchronous to `clk`, and the shift clock must stay well below the system clock rate.

Alongside the data path the block watches every frame for four faults. A receive overrun is bit 0 of the status vector. A data/clock phase violation is bit 1. A shift-clock count or timing fault is bit 2, judged against a local bit period of `BIT_CYC` system clocks. A transfer started without a fresh transmit word is bit 3. Each fault sets a sticky status bit. A matching enable bit decides whether that fault drives the shared error interrupt. Software clears the status bits by writing ones through a clear port. An optional auto-reset puts the framing logic back to its idle state on a clock fault.

Both data ports are valid/ready streams. The transmit side applies back-pressure: `tx_ready` stays low while an earlier word still waits to be copied into the shift register. The receive side cannot stall the master. If `rx_ready` stays low, the word is held, and a later frame that completes overwrites it and flags an overrun.

Top module: `sss_slave_err`

## Requirements
- R1: `tx_ready` is high exactly when the transmit buffer is empty, and a word is accepted on a cycle with `tx_valid` and `tx_ready` both high. The accepted word is copied into the shift register on a cycle where no frame is in progress and no edge arrives. `ser_out` always shows shift-register bit 15.
- R2: A frame is 16 rising edges of `ser_clk`. Each edge shifts `ser_in` in at bit 0. The sixteenth edge places the full word in `rx_data`, raises `rx_valid`, and pulses `rx_irq` for one cycle.
- R3: `rx_data` and `rx_valid` hold until a cycle with `rx_valid` and `rx_ready` both high. If a frame completes while an unread word remains, status bit 0 is set and the new word replaces the old one.
- R4: If the first edge of a frame arrives and no word has been copied into the shift register since the previous frame began, status bit 3 is set. The frame then shifts out the existing register contents, which is the previously received word.
- R5: The first edge of a frame that carries a freshly copied word pulses `tx_irq` for one cycle.
- R6: If `ser_in` changed within `PH_WIN` system clocks before a rising `ser_clk` edge, status bit 1 is set.
- R7: Status bit 2 is set when a frame is partly received and no edge has come for more than 1.5 bit periods, that is `3*BIT_CYC/2` clocks (a missing pulse).
- R8: An edge that arrives within 1.5 bit periods after a frame's sixteenth edge is an extra pulse and sets status bit 2. When auto-reset is off, that edge begins a new frame.
- R9: When `auto_rst_en` is high, a bit-2 fault discards the partial frame or the extra edge. It returns the bit counter to idle, fills the shift register with ones, and marks the transmit word as not fresh.
- R10: Status bits stay set until a cycle with `clr_valid` high and the matching `clr_mask` bit at 1. If a fault and a clear hit the same bit in the same cycle, the fault wins.
- R11: `err_irq` is high exactly when some status bit and its `err_en` bit are both 1.
- R12: After reset, all status bits, `rx_valid`, `err_irq`, `rx_irq` and `tx_irq` are 0, `tx_ready` is 1, and `ser_out` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_clk | input | 1 | Shift clock from the master |
| ser_in | input | 1 | Serial data from the master |
| ser_out | output | 1 | Serial data to the master |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Transmit buffer empty |
| tx_data | input | 16 | Transmit word |
| rx_valid | output | 1 | Received word available |
| rx_ready | input | 1 | Received word taken |
| rx_data | output | 16 | Received word |
| tx_irq | output | 1 | Pulse when a fresh word starts shifting |
| rx_irq | output | 1 | Pulse when a frame completes |
| err_en | input | 4 | Per-fault interrupt enables (bit0 overrun, bit1 phase, bit2 clock, bit3 transmit) |
| auto_rst_en | input | 1 | Reinitialise framing on clock faults |
| clr_valid | input | 1 | Status clear strobe |
| clr_mask | input | 4 | Write-one-to-clear mask for status bits |
| err_flags | output | 4 | Sticky fault status |
| err_irq | output | 1 | Shared error interrupt |

## Verification
A wrong bit counter shows up at the frame boundary. `rx_irq` fires early or late, or the extra-pulse check misjudges an edge, and the reference model sees this within one bit period of the fault. A corrupted shift register or freshness mark reaches `ser_out` on the next cycle. An edge-timing counter that is off by one moves the clock-fault flag by one cycle, and the per-cycle comparison against the behavioural model catches that directly. Sticky-flag and interrupt-gating faults appear at `err_flags` and `err_irq` in the cycle after the stimulus.

// File: rtl/sss_pkg.sv
package sss_pkg;
  localparam int NCAUSE = 4;
  localparam int ERR_OVR = 0;
  localparam int ERR_PHS = 1;
  localparam int ERR_CLK = 2;
  localparam int ERR_UND = 3;
endpackage

// File: rtl/sss_sampler.sv
module sss_sampler #(
  parameter int PH_WIN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ser_clk,
  input  logic ser_in,
  output logic rise,
  output logic phase_bad
);
  localparam int SW = $clog2(PH_WIN + 1) + 1;

  logic          clk_q, din_q;
  logic [SW-1:0] stab;
  logic          chg;

  assign chg       = ser_in != din_q;
  assign rise      = ser_clk & ~clk_q;
  assign phase_bad = rise & (chg | (stab < SW'(PH_WIN)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clk_q <= 1'b0;
      din_q <= 1'b0;
      stab  <= '0;
    end else begin
      clk_q <= ser_clk;
      din_q <= ser_in;
      if (chg) stab <= '0;
      else if (stab < SW'(PH_WIN)) stab <= stab + SW'(1);
    end
  end

  // R6: a rise cannot follow a rise in the next cycle
  a_r6_rise_gap: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/sss_framer.sv
module sss_framer #(
  parameter int WIDTH   = 16,
  parameter int BIT_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rise,
  input  logic auto_rst,
  output logic shift,
  output logic start,
  output logic done,
  output logic clk_bad,
  output logic reinit,
  output logic idle
);
  localparam int LIMIT = (3 * BIT_CYC) / 2;
  localparam int GW    = $clog2(LIMIT + 1);
  localparam int CW    = $clog2(WIDTH + 1);

  logic [CW-1:0] cnt, cnt_n;
  logic [GW-1:0] gap, gap_n;
  logic          guard, guard_n;

  assign idle = cnt == '0;

  always_comb begin
    shift   = 1'b0;
    start   = 1'b0;
    done    = 1'b0;
    clk_bad = 1'b0;
    reinit  = 1'b0;
    cnt_n   = cnt;
    gap_n   = gap;
    guard_n = guard;
    if (rise) begin
      gap_n = '0;
      if (guard) begin
        clk_bad = 1'b1;
        guard_n = 1'b0;
        if (auto_rst) begin
          reinit = 1'b1;
        end else begin
          shift = 1'b1;
          start = 1'b1;
          cnt_n = CW'(1);
        end
      end else begin
        shift = 1'b1;
        start = idle;
        if (cnt == CW'(WIDTH - 1)) begin
          done    = 1'b1;
          cnt_n   = '0;
          guard_n = 1'b1;
        end else begin
          cnt_n = cnt + CW'(1);
        end
      end
    end else if (!idle) begin
      if (gap == GW'(LIMIT)) begin
        clk_bad = 1'b1;
        if (auto_rst) begin
          reinit = 1'b1;
          cnt_n  = '0;
          gap_n  = '0;
        end
      end else begin
        gap_n = gap + GW'(1);
      end
    end else if (guard) begin
      if (gap == GW'(LIMIT)) begin
        guard_n = 1'b0;
        gap_n   = '0;
      end else begin
        gap_n = gap + GW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      gap   <= '0;
      guard <= 1'b0;
    end else begin
      cnt   <= cnt_n;
      gap   <= gap_n;
      guard <= guard_n;
    end
  end

  // R9: reinitialisation leaves the counter idle
  a_r9_reinit_idle: assert property (@(posedge clk) disable iff (!rst_n)
    reinit |=> idle);
  // R2: frame completions are never adjacent
  a_r2_done_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8: a completed frame leaves the counter at zero
  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> idle);
endmodule

// File: rtl/sss_datapath.sv
module sss_datapath #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_in,
  input  logic             shift,
  input  logic             start,
  input  logic             done,
  input  logic             reinit,
  input  logic             load_ok,
  input  logic             tx_valid,
  input  logic [WIDTH-1:0] tx_data,
  input  logic             rx_ready,
  output logic             ser_out,
  output logic             tx_ready,
  output logic             rx_valid,
  output logic [WIDTH-1:0] rx_data,
  output logic             tx_irq,
  output logic             rx_irq,
  output logic             overrun,
  output logic             underrun
);
  logic [WIDTH-1:0] shreg, txbuf, shifted;
  logic             tx_full, fresh, load, take;

  assign shifted  = {shreg[WIDTH-2:0], ser_in};
  assign load     = load_ok & tx_full & ~fresh;
  assign take     = rx_valid & rx_ready;
  assign tx_ready = ~tx_full;
  assign ser_out  = shreg[WIDTH-1];
  assign overrun  = done & rx_valid & ~rx_ready;
  assign underrun = start & ~fresh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg    <= '1;
      txbuf    <= '0;
      tx_full  <= 1'b0;
      fresh    <= 1'b0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
      tx_irq   <= 1'b0;
      rx_irq   <= 1'b0;
    end else begin
      tx_irq <= start & fresh;
      rx_irq <= done;
      if (reinit) shreg <= '1;
      else if (shift) shreg <= shifted;
      else if (load) shreg <= txbuf;
      if (reinit || start) fresh <= 1'b0;
      else if (load) fresh <= 1'b1;
      if (load) begin
        tx_full <= 1'b0;
      end else if (tx_valid && !tx_full) begin
        tx_full <= 1'b1;
        txbuf   <= tx_data;
      end
      if (done) begin
        rx_data  <= shifted;
        rx_valid <= 1'b1;
      end else if (take) begin
        rx_valid <= 1'b0;
      end
    end
  end

  // R1: copying from the buffer never collides with shifting
  a_r1_load_between_frames: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !shift);
  // R3: an unread word is held
  a_r3_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready && !done) |=> (rx_valid && $stable(rx_data)));
endmodule

// File: rtl/sss_errflags.sv
module sss_errflags #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic         clr_valid,
  input  logic [N-1:0] clr_mask,
  input  logic [N-1:0] err_en,
  output logic [N-1:0] flags,
  output logic         irq
);
  logic [N-1:0] keep;

  assign irq = |(flags & err_en);

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign keep[i] = flags[i] & ~(clr_valid & clr_mask[i]);
    always_ff @(posedge clk) begin
      if (!rst_n) flags[i] <= 1'b0;
      else flags[i] <= keep[i] | set[i];
    end
  end

  // R10: flags stay set while no clear is written
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_valid |=> ((flags & $past(flags)) == $past(flags)));
  // R10: a clear with no competing fault empties the masked bits
  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_valid && set == '0) |=> ((flags & $past(clr_mask)) == '0));
endmodule

// File: rtl/sss_slave_err.sv
module sss_slave_err #(
  parameter int WIDTH   = 16,
  parameter int BIT_CYC = 8,
  parameter int PH_WIN  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_clk,
  input  logic             ser_in,
  output logic             ser_out,
  input  logic             tx_valid,
  output logic             tx_ready,
  input  logic [WIDTH-1:0] tx_data,
  output logic             rx_valid,
  input  logic             rx_ready,
  output logic [WIDTH-1:0] rx_data,
  output logic             tx_irq,
  output logic             rx_irq,
  input  logic [3:0]       err_en,
  input  logic             auto_rst_en,
  input  logic             clr_valid,
  input  logic [3:0]       clr_mask,
  output logic [3:0]       err_flags,
  output logic             err_irq
);
  import sss_pkg::*;

  logic rise, phase_bad, shift, start, done, clk_bad, reinit, idle;
  logic overrun, underrun;
  logic [NCAUSE-1:0] set;

  sss_sampler #(.PH_WIN(PH_WIN)) u_smp (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_in(ser_in),
    .rise(rise), .phase_bad(phase_bad));

  sss_framer #(.WIDTH(WIDTH), .BIT_CYC(BIT_CYC)) u_frm (
    .clk(clk), .rst_n(rst_n), .rise(rise), .auto_rst(auto_rst_en),
    .shift(shift), .start(start), .done(done), .clk_bad(clk_bad),
    .reinit(reinit), .idle(idle));

  sss_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .shift(shift), .start(start),
    .done(done), .reinit(reinit), .load_ok(idle & ~rise),
    .tx_valid(tx_valid), .tx_data(tx_data), .rx_ready(rx_ready),
    .ser_out(ser_out), .tx_ready(tx_ready), .rx_valid(rx_valid),
    .rx_data(rx_data), .tx_irq(tx_irq), .rx_irq(rx_irq),
    .overrun(overrun), .underrun(underrun));

  always_comb begin
    set          = '0;
    set[ERR_OVR] = overrun;
    set[ERR_PHS] = phase_bad;
    set[ERR_CLK] = clk_bad;
    set[ERR_UND] = underrun;
  end

  sss_errflags #(.N(NCAUSE)) u_flg (
    .clk(clk), .rst_n(rst_n), .set(set), .clr_valid(clr_valid),
    .clr_mask(clr_mask), .err_en(err_en), .flags(err_flags), .irq(err_irq));

  // R11: with all enables off the interrupt stays low
  a_r11_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (err_en == 4'h0) |-> !err_irq);
  // R4: a transmit fault leaves bit 3 set next cycle
  a_r4_underrun_flag: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> err_flags[ERR_UND]);
endmodule

// File: tb/sss_slave_err_tb_top.sv
`timescale 1ns/1ps
module sss_slave_err_tb_top;
  localparam int PH  = 2;
  localparam int LIM = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_in = 1'b0, tx_valid = 1'b0, rx_ready = 1'b0;
  logic auto_rst_en = 1'b0, clr_valid = 1'b0;
  logic [15:0] tx_data = '0;
  logic [3:0] err_en = 4'hF, clr_mask = 4'h0;
  logic ser_out, tx_ready, rx_valid, tx_irq, rx_irq, err_irq;
  logic [15:0] rx_data;
  logic [3:0] err_flags;

  int vectors = 0, miscompares = 0, cyc = 0;
  bit go = 1'b0;

  always #2.5 clk = ~clk;

  sss_slave_err dut_i (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_in(ser_in), .ser_out(ser_out),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .tx_irq(tx_irq), .rx_irq(rx_irq), .err_en(err_en), .auto_rst_en(auto_rst_en),
    .clr_valid(clr_valid), .clr_mask(clr_mask), .err_flags(err_flags), .err_irq(err_irq));

  // behavioural reference model
  logic        m_sp = 0, m_dp = 0, m_guard = 0, m_txfull = 0, m_fresh = 0;
  logic        m_rxv = 0, m_rxirq = 0, m_txirq = 0;
  logic [15:0] m_sh = '1, m_txb = '0, m_rxb = '0;
  logic [3:0]  m_flags = '0;
  int          m_cnt = 0, m_gap = 0, m_stab = 0;

  always @(posedge clk) begin
    logic e, chg, shf, strt, dn, ri, ld, n_guard, n_fresh;
    logic [3:0] st;
    int n_cnt, n_gap;
    if (!rst_n) begin
      m_sp = 0; m_dp = 0; m_guard = 0; m_txfull = 0; m_fresh = 0;
      m_rxv = 0; m_rxirq = 0; m_txirq = 0; m_sh = '1; m_txb = '0; m_rxb = '0;
      m_flags = '0; m_cnt = 0; m_gap = 0; m_stab = 0;
    end else begin
      e = ser_clk && !m_sp;
      chg = ser_in != m_dp;
      st = '0; shf = 0; strt = 0; dn = 0; ri = 0;
      n_cnt = m_cnt; n_gap = m_gap; n_guard = m_guard;
      if (e && (chg || m_stab < PH)) st[1] = 1;
      if (e) begin
        n_gap = 0;
        if (m_guard) begin
          st[2] = 1; n_guard = 0;
          if (auto_rst_en) ri = 1;
          else begin shf = 1; strt = 1; n_cnt = 1; end
        end else begin
          shf = 1; strt = (m_cnt == 0);
          if (m_cnt == 15) begin dn = 1; n_cnt = 0; n_guard = 1; end
          else n_cnt = m_cnt + 1;
        end
      end else if (m_cnt != 0) begin
        if (m_gap == LIM) begin
          st[2] = 1;
          if (auto_rst_en) begin ri = 1; n_cnt = 0; n_gap = 0; end
        end else n_gap = m_gap + 1;
      end else if (m_guard) begin
        if (m_gap == LIM) begin n_guard = 0; n_gap = 0; end
        else n_gap = m_gap + 1;
      end
      ld = (m_cnt == 0) && !e && m_txfull && !m_fresh;
      if (strt && !m_fresh) st[3] = 1;
      m_txirq = strt && m_fresh;
      m_rxirq = dn;
      if (dn) begin
        if (m_rxv && !rx_ready) st[0] = 1;
        m_rxb = {m_sh[14:0], ser_in};
        m_rxv = 1;
      end else if (m_rxv && rx_ready) m_rxv = 0;
      n_fresh = m_fresh;
      if (ri || strt) n_fresh = 0; else if (ld) n_fresh = 1;
      if (ri) m_sh = '1;
      else if (shf) m_sh = {m_sh[14:0], ser_in};
      else if (ld) m_sh = m_txb;
      if (ld) m_txfull = 0;
      else if (tx_valid && !m_txfull) begin m_txfull = 1; m_txb = tx_data; end
      m_flags = (m_flags & ~(clr_valid ? clr_mask : 4'h0)) | st;
      if (chg) m_stab = 0; else if (m_stab < PH) m_stab = m_stab + 1;
      m_fresh = n_fresh; m_cnt = n_cnt; m_gap = n_gap; m_guard = n_guard;
      m_sp = ser_clk; m_dp = ser_in;
    end
  end

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, got, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (go) begin
      chk("R1 ser_out", 16'(ser_out), 16'(m_sh[15]));
      chk("R1 tx_ready", 16'(tx_ready), 16'(!m_txfull));
      chk("R2 rx_irq", 16'(rx_irq), 16'(m_rxirq));
      chk("R3 rx_valid", 16'(rx_valid), 16'(m_rxv));
      chk("R3 rx_data", rx_data, m_rxb);
      chk("R5 tx_irq", 16'(tx_irq), 16'(m_txirq));
      chk("R10 err_flags", 16'(err_flags), 16'(m_flags));
      chk("R11 err_irq", 16'(err_irq), 16'(|(m_flags & err_en)));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic send_bit(input logic b, input bit late);
    @(negedge clk) ser_clk = 0;
    if (!late) ser_in = b;
    repeat (3) @(negedge clk);
    if (late) ser_in = b;
    @(negedge clk) ser_clk = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic send_word(input logic [15:0] w, input int n, input int late_idx);
    for (int i = 0; i < n; i++) send_bit(w[15 - (i % 16)], i == late_idx);
    @(negedge clk) ser_clk = 0;
    repeat (20) @(negedge clk);
  endtask

  task automatic put_tx(input logic [15:0] w);
    @(negedge clk) begin tx_valid = 1; tx_data = w; end
    @(negedge clk) tx_valid = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic take_rx();
    @(negedge clk) rx_ready = 1;
    @(negedge clk) rx_ready = 0;
  endtask

  task automatic clear_all();
    @(negedge clk) begin clr_valid = 1; clr_mask = 4'hF; end
    @(negedge clk) begin clr_valid = 0; clr_mask = 4'h0; end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    go = 1;
    #1;
    chk("R12 flags", 16'(err_flags), 16'h0);
    chk("R12 tx_ready", 16'(tx_ready), 16'h1);
    chk("R12 ser_out", 16'(ser_out), 16'h1);
    chk("R12 err_irq", 16'(err_irq), 16'h0);

    put_tx(16'hA5C3);
    send_word(16'h1234, 16, -1);
    chk("R2 rx_data", rx_data, 16'h1234);
    chk("R2 no fault", 16'(err_flags), 16'h0);
    take_rx();

    send_word(16'hBEEF, 16, -1);
    chk("R4 underrun flag", 16'(err_flags[3]), 16'h1);
    chk("R11 irq on", 16'(err_irq), 16'h1);
    take_rx();
    clear_all();
    chk("R10 cleared", 16'(err_flags), 16'h0);

    put_tx(16'h1111);
    send_word(16'h0F0F, 16, -1);
    put_tx(16'h2222);
    send_word(16'h5555, 16, -1);
    chk("R3 overrun flag", 16'(err_flags[0]), 16'h1);
    chk("R3 overwrite", rx_data, 16'h5555);
    take_rx();
    clear_all();

    err_en = 4'h0;
    put_tx(16'h3333);
    send_word(16'h6666, 16, 5);
    chk("R6 phase flag", 16'(err_flags[1]), 16'h1);
    chk("R11 gated", 16'(err_irq), 16'h0);
    take_rx();
    clear_all();
    err_en = 4'hF;

    auto_rst_en = 0;
    put_tx(16'h4444);
    send_word(16'h7777, 15, -1);
    chk("R7 missing pulse", 16'(err_flags[2]), 16'h1);
    send_word(16'h0000, 1, -1);
    take_rx();
    clear_all();

    auto_rst_en = 1;
    put_tx(16'h4C4C);
    send_word(16'h1357, 15, -1);
    chk("R9 missing auto", 16'(err_flags[2]), 16'h1);
    chk("R9 ser_out ones", 16'(ser_out), 16'h1);
    clear_all();
    put_tx(16'h9999);
    send_word(16'h2468, 17, -1);
    chk("R9 extra auto", 16'(err_flags[2]), 16'h1);
    take_rx();
    clear_all();
    chk("R9 quiet after", 16'(err_flags), 16'h0);

    auto_rst_en = 0;
    put_tx(16'hABCD);
    send_word(16'hC0DE, 17, -1);
    chk("R8 extra pulse", 16'(err_flags[2]), 16'h1);
    send_word(16'hFFFE, 15, -1);
    chk("R8 new frame done", 16'(rx_valid), 16'h1);
    take_rx();
    clear_all();
    chk("R10 final clear", 16'(err_flags), 16'h0);

    repeat (5) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule